// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer with Reading Hold

This block is the digital half of a dual-slope integrating converter. A prescaler turns the oscillator clock into a count clock at one quarter of its rate. On that count clock a sequencer walks a fixed loop of three phases:

- **Zero-correction (AZ):** shorts out offsets.
- **Signal integrate:** integrates the unknown input for a fixed time.
- **De-integrate:** ramps the integrator back toward zero with the reference of opposite sign.

The sequencer drives one enable per analog switch group and a reference-sign select, and it samples a single comparator bit that reports which side of zero the integrator sits on.

The number of count clocks spent in de-integrate before the comparator flips is the magnitude of the result. It is counted directly in BCD: three decimal digits plus a leading half digit that is either 0 or 1. A sign flag and an overrange flag go with it. The result is copied to the output register once per conversion, at the end of de-integrate. A hold input blocks that copy, so a reading can be frozen on the display for as long as hold stays high.

Top module: `dslope_seq`

## Requirements
- R1: One count clock occurs every 4 oscillator cycles. Each conversion spans exactly 4000 count clocks, so successive rises of `int_en` are 16000 oscillator cycles apart.
- R2: The phases run in the fixed order zero-correction, integrate, de-integrate, then zero-correction again, and exactly one of `az_en`, `int_en`, `deint_en` is high at any time. After reset is released, the first zero-correction phase lasts 1000 count clocks (4000 oscillator cycles).
- R3: `int_en` stays high for exactly 1000 count clocks (4000 oscillator cycles) in every conversion.
- R4: The comparator is sampled once per count clock during de-integrate, and de-integrate ends on the first count clock at which `cmp_pos` differs from its value latched at the end of integrate. The reading is the number of count clocks that precede that flip, not counting the first de-integrate count clock. De-integrate therefore lasts reading + 2 count clocks.
- R5: The reading appears as `rd_thou` (the leading 1) and `rd_bcd`, which holds hundreds in [11:8], tens in [7:4] and units in [3:0], each a BCD digit of value 0 to 9. For an input of magnitude m reference units (m up to 1998), the reading is m. `rd_neg` is 1 when `cmp_pos` was 0 at the end of integrate.
- R6: During de-integrate, `ref_neg` equals the latched comparator value, so the reference opposes the input. `ref_neg` is 0 outside de-integrate.
- R7: If no flip occurs by the 2000th de-integrate count clock, de-integrate stops there. The output then shows 1999 with `rd_ovr` = 1; otherwise `rd_ovr` = 0.
- R8: A zero input reads 000, and `rd_neg` still reflects the comparator level latched at the end of integrate.
- R9: The outputs change only on the clock edge after de-integrate ends. While a conversion is in progress they show the previous reading.
- R10: When `hold` is 1 on the edge where a new reading would be published, the outputs keep their previous value. This holds for any number of conversions. The level of `hold` at other times has no effect.
- R11: Synchronous reset starts the sequencer in zero-correction (`az_en` = 1) and clears the reading, `rd_neg` and `rd_ovr` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Blocks publication of a new reading while high |
| cmp_pos | input | 1 | Comparator: 1 when the integrator is above zero |
| az_en | output | 1 | Zero-correction switch enable |
| int_en | output | 1 | Signal-integrate switch enable |
| deint_en | output | 1 | De-integrate switch enable |
| ref_neg | output | 1 | Reference sign select: 1 applies the negative reference |
| rd_neg | output | 1 | Sign of the displayed reading (1 = negative) |
| rd_ovr | output | 1 | Displayed reading is overrange |
| rd_thou | output | 1 | Leading half digit of the reading |
| rd_bcd | output | 12 | Hundreds, tens and units BCD digits |

## Verification
Publication of a finished reading and the hold gate meet on the same clock edge. The bench provokes this by changing `hold` in the very cycle after `deint_en` falls, which is the cycle the result is handed to the output register. It does this in both directions: holding a new reading off and releasing a frozen one. It then judges the outputs a few cycles later against the reading it computes from the modelled integrator. Random `hold` levels during integrate show that the gate acts only at that one edge.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  typedef enum logic [1:0] {
    PH_AZ    = 2'd0,
    PH_INT   = 2'd1,
    PH_DEINT = 2'd2
  } phase_t;

  // Number of full BCD digits below the leading half digit.
  localparam int DIGITS = 3;
endpackage

// File: rtl/dsq_prescale.sv
module dsq_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || cnt == LAST) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  generate
    if (DIV > 1) begin : g_chk
      // R1: count-clock enables never come back to back
      a_r1_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/dsq_bcd_count.sv
module dsq_bcd_count #(
  parameter int DIGITS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                inc,
  output logic                thou,
  output logic [4*DIGITS-1:0] dig
);
  logic [DIGITS:0] carry;
  assign carry[0] = inc;

  genvar g;
  generate
    for (g = 0; g < DIGITS; g++) begin : g_dig
      logic [3:0] q;
      assign carry[g+1]     = carry[g] && (q == 4'd9);
      assign dig[4*g +: 4]  = q;

      always_ff @(posedge clk) begin
        if (rst || clr)    q <= 4'd0;
        else if (carry[g]) q <= (q == 4'd9) ? 4'd0 : q + 4'd1;
      end

      // R5: every digit stays a legal BCD code
      a_r5_digit_range: assert property (@(posedge clk) disable iff (rst)
        q <= 4'd9);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr)         thou <= 1'b0;
    else if (carry[DIGITS]) thou <= 1'b1;
  end
endmodule

// File: rtl/dsq_sequencer.sv
module dsq_sequencer
  import dsq_pkg::*;
#(
  parameter int INT_CNT    = 1000,
  parameter int DEINT_SPAN = 2000,
  parameter int TOTAL      = 4000
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  input  logic   cmp_pos,
  output phase_t phase,
  output logic   pos_lat,
  output logic   bcd_clr,
  output logic   bcd_inc,
  output logic   done,
  output logic   res_ovr,
  output logic   res_neg
);
  localparam int CW        = $clog2(TOTAL);
  localparam int INT_LAST  = INT_CNT - 1;
  localparam int DEINT_END = INT_CNT + DEINT_SPAN - 1;
  localparam int AZ_RESET  = INT_CNT + DEINT_SPAN;

  // Position within the conversion, counted from the start of integrate.
  logic [CW-1:0] cyc;
  logic          flip, d_first, d_last, i_last;

  assign flip    = (cmp_pos != pos_lat);
  assign d_first = (cyc == CW'(INT_CNT));
  assign d_last  = (cyc == CW'(DEINT_END));
  assign i_last  = (cyc == CW'(INT_LAST));

  assign bcd_clr = tick && (phase == PH_INT) && i_last;
  assign bcd_inc = tick && (phase == PH_DEINT) && !flip && !d_first && !d_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_AZ;
      cyc     <= CW'(AZ_RESET);
      pos_lat <= 1'b0;
      done    <= 1'b0;
      res_ovr <= 1'b0;
      res_neg <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (phase)
          PH_AZ: begin
            if (cyc == CW'(TOTAL - 1)) begin
              phase <= PH_INT;
              cyc   <= '0;
            end else begin
              cyc <= cyc + 1'b1;
            end
          end
          PH_INT: begin
            cyc <= cyc + 1'b1;
            if (i_last) begin
              phase   <= PH_DEINT;
              pos_lat <= cmp_pos;
            end
          end
          PH_DEINT: begin
            cyc <= cyc + 1'b1;
            if (flip || d_last) begin
              phase   <= PH_AZ;
              done    <= 1'b1;
              res_ovr <= !flip;
              res_neg <= !pos_lat;
            end
          end
          default: phase <= PH_AZ;
        endcase
      end
    end
  end

  // R1: position never leaves the conversion window
  a_r1_window: assert property (@(posedge clk) disable iff (rst)
    cyc < CW'(TOTAL));

  // R2: integrate is entered only from zero-correction
  a_r2_enter_int: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_INT && $past(phase) != PH_INT) |-> $past(phase) == PH_AZ);

  // R2: zero-correction is entered only from de-integrate
  a_r2_enter_az: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_AZ && $past(phase) != PH_AZ) |-> $past(phase) == PH_DEINT);

  // R3: de-integrate starts exactly when integrate has used its full length
  a_r3_int_len: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DEINT && $past(phase) == PH_INT) |-> cyc == CW'(INT_CNT));

  // R7: de-integrate never runs past its span
  a_r7_deint_bound: assert property (@(posedge clk) disable iff (rst)
    phase == PH_DEINT |-> (cyc >= CW'(INT_CNT) && cyc <= CW'(DEINT_END)));

  // R9: a result is offered only as de-integrate closes
  a_r9_done_edge: assert property (@(posedge clk) disable iff (rst)
    done |-> (phase == PH_AZ && $past(phase) == PH_DEINT));
endmodule

// File: rtl/dsq_hold_latch.sv
module dsq_hold_latch #(
  parameter int DIGITS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hold,
  input  logic                done,
  input  logic                res_ovr,
  input  logic                res_neg,
  input  logic                cnt_thou,
  input  logic [4*DIGITS-1:0] cnt_dig,
  output logic                rd_neg,
  output logic                rd_ovr,
  output logic                rd_thou,
  output logic [4*DIGITS-1:0] rd_bcd
);
  localparam logic [4*DIGITS-1:0] ALL_NINES = {DIGITS{4'd9}};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_neg  <= 1'b0;
      rd_ovr  <= 1'b0;
      rd_thou <= 1'b0;
      rd_bcd  <= '0;
    end else if (done && !hold) begin
      rd_neg  <= res_neg;
      rd_ovr  <= res_ovr;
      rd_thou <= res_ovr ? 1'b1 : cnt_thou;
      rd_bcd  <= res_ovr ? ALL_NINES : cnt_dig;
    end
  end

  // R10: hold freezes the published reading
  a_r10_hold_freeze: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(rd_bcd) && $stable(rd_thou) && $stable(rd_neg) && $stable(rd_ovr)));

  // R9: nothing moves unless a finished result is offered
  a_r9_no_partial: assert property (@(posedge clk) disable iff (rst)
    !done |=> ($stable(rd_bcd) && $stable(rd_thou) && $stable(rd_neg) && $stable(rd_ovr)));
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dsq_pkg::*;
#(
  parameter int DIV        = 4,
  parameter int INT_CNT    = 1000,
  parameter int DEINT_SPAN = 2000,
  parameter int TOTAL      = 4000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              cmp_pos,
  output logic              az_en,
  output logic              int_en,
  output logic              deint_en,
  output logic              ref_neg,
  output logic              rd_neg,
  output logic              rd_ovr,
  output logic              rd_thou,
  output logic [4*DIGITS-1:0] rd_bcd
);
  phase_t                phase;
  logic                  tick, pos_lat, bcd_clr, bcd_inc, done, res_ovr, res_neg;
  logic                  cnt_thou;
  logic [4*DIGITS-1:0]   cnt_dig;

  dsq_prescale #(.DIV(DIV)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  dsq_sequencer #(
    .INT_CNT    (INT_CNT),
    .DEINT_SPAN (DEINT_SPAN),
    .TOTAL      (TOTAL)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .cmp_pos (cmp_pos),
    .phase   (phase),
    .pos_lat (pos_lat),
    .bcd_clr (bcd_clr),
    .bcd_inc (bcd_inc),
    .done    (done),
    .res_ovr (res_ovr),
    .res_neg (res_neg)
  );

  dsq_bcd_count #(.DIGITS(DIGITS)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (bcd_clr),
    .inc  (bcd_inc),
    .thou (cnt_thou),
    .dig  (cnt_dig)
  );

  dsq_hold_latch #(.DIGITS(DIGITS)) u_out (
    .clk      (clk),
    .rst      (rst),
    .hold     (hold),
    .done     (done),
    .res_ovr  (res_ovr),
    .res_neg  (res_neg),
    .cnt_thou (cnt_thou),
    .cnt_dig  (cnt_dig),
    .rd_neg   (rd_neg),
    .rd_ovr   (rd_ovr),
    .rd_thou  (rd_thou),
    .rd_bcd   (rd_bcd)
  );

  // Switch controls come straight from the phase register.
  assign az_en    = (phase == PH_AZ);
  assign int_en   = (phase == PH_INT);
  assign deint_en = (phase == PH_DEINT);
  assign ref_neg  = deint_en && pos_lat;

  // R6: the reference always opposes the input that was integrated
  a_r6_ref_oppose: assert property (@(posedge clk) disable iff (rst)
    ($rose(deint_en)) |-> ref_neg == $past(cmp_pos));
endmodule

// File: tb/dslope_seq_tb.sv
module dslope_seq_tb;
  logic        clk = 1'b0;
  logic        rst, hold, cmp_pos;
  logic        az_en, int_en, deint_en, ref_neg, rd_neg, rd_ovr, rd_thou;
  logic [11:0] rd_bcd;

  always #2.5 clk = ~clk;

  dslope_seq u_dut (
    .clk(clk), .rst(rst), .hold(hold), .cmp_pos(cmp_pos),
    .az_en(az_en), .int_en(int_en), .deint_en(deint_en), .ref_neg(ref_neg),
    .rd_neg(rd_neg), .rd_ovr(rd_ovr), .rd_thou(rd_thou), .rd_bcd(rd_bcd)
  );

  int  nchk = 0, nerr = 0;
  bit  finished = 0;
  int  vin = 0;
  int  edges = 0;

  // Behavioural integrator and comparator, stepped on the count clock.
  int  acc, nacc, bpre;
  logic cmp_q;
  assign cmp_pos = cmp_q;

  always @(posedge clk) begin
    if (rst) begin
      bpre  <= 0;
      acc   <= 0;
      cmp_q <= 1'b0;
    end else begin
      edges <= edges + 1;
      bpre  <= (bpre == 3) ? 0 : bpre + 1;
      if (bpre == 3) begin
        nacc = acc;
        if (az_en)         nacc = 0;
        else if (int_en)   nacc = acc + vin;
        else if (deint_en) nacc = ref_neg ? acc - 1000 : acc + 1000;
        acc <= nacc;
        if (nacc > 0)      cmp_q <= 1'b1;
        else if (nacc < 0) cmp_q <= 1'b0;
      end
    end
  end

  function automatic logic [12:0] pack(int n);
    return {(n >= 1000) ? 1'b1 : 1'b0, 4'((n / 100) % 10), 4'((n / 10) % 10), 4'(n % 10)};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", edges, 180000);
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  int   vplan[11];
  bit   hplan[11];
  logic [12:0] disp;
  bit   dneg, dovr;

  initial begin
    void'($urandom(32'd4242));
    vplan = '{0, 1998, -1, 0, -2500, 1999, 0, 0, 0, 0, 1000};
    hplan = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0};
    vplan[6] = int'($urandom % 1998) + 1;
    vplan[7] = -(int'($urandom % 1998) + 1);
    vplan[8] = int'($urandom % 1999);
    vplan[9] = -(int'($urandom % 1998) + 1);
    disp = '0; dneg = 0; dovr = 0;

    rst = 1'b1; hold = 1'b0; vin = vplan[0];
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk({az_en, int_en, deint_en} == 3'b100, "R11 phase", {az_en, int_en, deint_en}, 4);
    chk({rd_thou, rd_bcd} == 13'd0, "R11 reading", {rd_thou, rd_bcd}, 0);
    chk({rd_neg, rd_ovr, ref_neg} == 3'b000, "R11 flags", {rd_neg, rd_ovr, ref_neg}, 0);
    rst = 1'b0;

    while (!int_en) @(negedge clk);
    chk(edges == 4000, "R2 first zero-correction", edges, 4000);

    begin
      int last_rise;
      last_rise = edges;
      for (int i = 0; i < 11; i++) begin
        int  a, n, exp_ticks, exp_val;
        bit  ovr, cmp_rec, exp_neg;
        if (i > 0) begin
          chk(edges - last_rise == 16000, "R1 conversion period", edges - last_rise, 16000);
          last_rise = edges;
        end
        hold = 1'(($urandom % 2)); // R10: hold level mid-conversion is ignored
        n = 0;
        while (int_en) begin
          n++;
          @(negedge clk);
        end
        chk(n == 4000, "R3 integrate length", n, 4000);

        // First cycle of de-integrate.
        cmp_rec = cmp_q;
        a = (vin < 0) ? -vin : vin;
        ovr = (a >= 1999);
        exp_val = ovr ? 1999 : a;
        exp_ticks = ovr ? 2000 : a + 2;
        exp_neg = (vin == 0) ? !cmp_rec : (vin < 0);
        chk({az_en, int_en, deint_en} == 3'b001, "R2 order", {az_en, int_en, deint_en}, 1);
        chk(ref_neg == !exp_neg, "R6 reference sign", ref_neg, !exp_neg);
        chk({rd_thou, rd_bcd} == disp, "R9 no partial reading", {rd_thou, rd_bcd}, disp);

        n = 0;
        while (deint_en) begin
          n++;
          @(negedge clk);
        end
        if (ovr) chk(n == exp_ticks * 4, "R7 overrange span", n, exp_ticks * 4);
        else     chk(n == exp_ticks * 4, "R4 de-integrate length", n, exp_ticks * 4);
        chk(ref_neg == 1'b0, "R6 reference idle", ref_neg, 0);

        // Result is offered in this cycle: set hold to collide with it.
        hold = hplan[i];
        repeat (3) @(negedge clk);
        if (!hplan[i]) begin
          disp = pack(exp_val);
          dneg = exp_neg;
          dovr = ovr;
        end
        if (hplan[i])      chk({rd_thou, rd_bcd} == disp, "R10 held reading", {rd_thou, rd_bcd}, disp);
        else if (vin == 0) chk({rd_thou, rd_bcd} == disp, "R8 zero reading", {rd_thou, rd_bcd}, disp);
        else               chk({rd_thou, rd_bcd} == disp, "R5 reading", {rd_thou, rd_bcd}, disp);
        if (vin == 0) chk(rd_neg == dneg, "R8 polarity at zero", rd_neg, dneg);
        else          chk(rd_neg == dneg, "R5 polarity", rd_neg, dneg);
        chk(rd_ovr == dovr, "R7 overrange flag", rd_ovr, dovr);

        if (i < 10) begin
          vin = vplan[i + 1];
          while (!int_en) @(negedge clk);
        end
      end
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule